// File: doc/BRIEF.md
# Selectable-Rate Periodic Tick Interrupt

This block is a free-running binary divider. Software picks one of eight counter taps, and so one of eight interrupt periods, through a 3-bit rate field. Each time the chosen tap rolls over, a sticky pending flag is set. An interrupt request goes out while that flag is set and the enable bit is on. Software clears the flag by writing 1 to an acknowledge bit that always reads back as zero.

All control and status sit in one 8-bit register on a simple bus port: an address compare, a write strobe, write data and combinational read data. While the run bit is clear, the divider is held at zero. Setting the run bit starts counting from zero, so the first flag comes exactly one full period after the write that starts the divider.

The rate field should only be changed while the divider is stopped. The result of changing it while running is not specified.

Top module: `rate_tick_irq`

## Requirements
- R1: After reset, the register reads 0x00 and `irq` is 0.
- R2: The register is at address 0x1C. Bit 7 is the pending flag (read-only). Bits 6:4 hold the rate code, bit 2 the interrupt enable and bit 1 the run bit; these three fields are read/write.
- R3: Bits 3 and 0 always read as 0. Writes to bit 0 and to bit 7 have no effect.
- R4: While the run bit is 0, the divider is held at zero. After the write that sets the run bit, the flag is set by exactly the 2^k-th following clock edge, where 2^k is the selected period. A stop and restart begins the period again.
- R5: Rate codes 0 to 7 select periods of 2^15, 2^13, 2^11, 2^10, 2^9, 2^7, 2^3 and 2^1 reference clocks.
- R6: The pending flag is set only by a rollover. Once set, it stays set through further rollovers, writes of 0 to bit 3, and clearing the run bit.
- R7: Writing 1 to bit 3 clears the pending flag on that clock edge.
- R8: When a rollover and an acknowledge write fall on the same clock edge, the flag ends up set.
- R9: `irq` is 1 exactly when the pending flag and the enable bit are both 1.
- R10: Writes to any other address change nothing. Reads from any other address return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, which also clocks the divider |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside the block |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data; the register when the address matches, otherwise 0 |
| irq | output | 1 | Interrupt request |

## Verification
The checker tests several relations on every cycle. It ties `irq` to the flag and enable bits seen on the read port, and checks that the reserved bits read 0 and that non-matching reads return 0. It checks that a rollover always leaves the flag set and that an acknowledge clears it only when no rollover coincides. It also checks that a stopped divider sits at zero and that the flag rises only after a rollover.

Other behaviour can only be shown by the bench's scenarios. These cover the exact period for every rate code, the restart from zero after a stop, the ignored writes to unused bits and other addresses, and the collision between an acknowledge and a rollover landing on one particular edge.

// File: rtl/rtim_pkg.sv
package rtim_pkg;
  localparam int RATE_W   = 3;
  localparam int NUM_TAPS = 1 << RATE_W;

  localparam int FLAG_BIT = 7;
  localparam int RATE_LSB = 4;
  localparam int ACK_BIT  = 3;
  localparam int IE_BIT   = 2;
  localparam int RUN_BIT  = 1;

  // period exponent for each rate code
  function automatic int tap_exp(input int code);
    case (code)
      0:       return 15;
      1:       return 13;
      2:       return 11;
      3:       return 10;
      4:       return 9;
      5:       return 7;
      6:       return 3;
      default: return 1;
    endcase
  endfunction

  function automatic int widest_tap();
    int m;
    m = 1;
    for (int i = 0; i < NUM_TAPS; i++) begin
      if (tap_exp(i) > m) m = tap_exp(i);
    end
    return m;
  endfunction
endpackage

// File: rtl/rtim_divider.sv
module rtim_divider #(
  parameter int CNT_W  = rtim_pkg::widest_tap(),
  parameter int RATE_W = rtim_pkg::RATE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [RATE_W-1:0] rate,
  output logic [CNT_W-1:0]  count,
  output logic              rollover
);
  localparam int NTAP = 1 << RATE_W;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [NTAP-1:0]  tap_full;

  for (genvar i = 0; i < NTAP; i++) begin : g_tap
    localparam int E = rtim_pkg::tap_exp(i);
    assign tap_full[i] = &cnt_q[E-1:0];
  end

  always_comb begin
    cnt_d = run ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign rollover = run & tap_full[rate];
  assign count    = cnt_q;
endmodule

// File: rtl/rtim_regs.sv
module rtim_regs #(
  parameter int DATA_W = 8,
  parameter int RATE_W = rtim_pkg::RATE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rollover,
  output logic [RATE_W-1:0] rate,
  output logic              ie,
  output logic              run,
  output logic              flag,
  output logic [DATA_W-1:0] rdata
);
  import rtim_pkg::*;

  logic              wr_en;
  logic              ack;
  logic [RATE_W-1:0] rate_q, rate_d;
  logic              ie_q, ie_d, run_q, run_d, flag_q, flag_d;

  assign wr_en = sel & wr;
  assign ack   = wr_en & wdata[ACK_BIT];

  always_comb begin
    rate_d = rate_q;
    ie_d   = ie_q;
    run_d  = run_q;
    if (wr_en) begin
      rate_d = wdata[RATE_LSB +: RATE_W];
      ie_d   = wdata[IE_BIT];
      run_d  = wdata[RUN_BIT];
    end
    if (rollover)  flag_d = 1'b1;
    else if (ack)  flag_d = 1'b0;
    else           flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= '0;
      ie_q   <= 1'b0;
      run_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      rate_q <= rate_d;
      ie_q   <= ie_d;
      run_q  <= run_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    rdata = '0;
    rdata[FLAG_BIT]               = flag_q;
    rdata[RATE_LSB +: RATE_W]     = rate_q;
    rdata[IE_BIT]                 = ie_q;
    rdata[RUN_BIT]                = run_q;
  end

  assign rate = rate_q;
  assign ie   = ie_q;
  assign run  = run_q;
  assign flag = flag_q;
endmodule

// File: rtl/rate_tick_irq.sv
module rate_tick_irq #(
  parameter int          ADDR_W   = 8,
  parameter int          DATA_W   = 8,
  parameter logic [7:0]  REG_ADDR = 8'h1C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int RATE_W = rtim_pkg::RATE_W;
  localparam int CNT_W  = rtim_pkg::widest_tap();

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic              hit;
  logic [RATE_W-1:0] rate;
  logic              ie, run, flag, rollover;
  logic [CNT_W-1:0]  count;
  logic [DATA_W-1:0] reg_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign hit = (bus_addr == REG_ADDR[ADDR_W-1:0]);

  rtim_divider #(.CNT_W(CNT_W), .RATE_W(RATE_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .run      (run),
    .rate     (rate),
    .count    (count),
    .rollover (rollover)
  );

  rtim_regs #(.DATA_W(DATA_W), .RATE_W(RATE_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .sel      (hit),
    .wr       (bus_wr),
    .wdata    (bus_wdata),
    .rollover (rollover),
    .rate     (rate),
    .ie       (ie),
    .run      (run),
    .flag     (flag),
    .rdata    (reg_val)
  );

  assign bus_rdata = hit ? reg_val : '0;
  assign irq       = flag & ie;
endmodule

// File: rtl/rtim_chk.sv
module rtim_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hit,
  input logic              wr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              irq,
  input logic              rollover,
  input logic              flag,
  input logic              run,
  input logic [CNT_W-1:0]  count
);
  // R9
  irq_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (irq == (rdata[7] && rdata[2])));
  // R3
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (rdata[3] == 1'b0 && rdata[0] == 1'b0));
  // R10
  other_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (rdata == '0));
  // R7
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && wr && wdata[3] && !rollover) |=> !flag);
  // R8
  roll_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rollover |=> flag);
  // R6
  flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(rollover));
  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(hit && wr && wdata[3])) |=> flag);
  // R4
  hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (count == '0));
endmodule

bind rate_tick_irq rtim_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .hit      (hit),
  .wr       (bus_wr),
  .wdata    (bus_wdata),
  .rdata    (bus_rdata),
  .irq      (irq),
  .rollover (rollover),
  .flag     (flag),
  .run      (run),
  .count    (count)
);

// File: tb/rate_tick_irq_tb.sv
`timescale 1ns/1ps
module rate_tick_irq_tb;
  localparam logic [7:0] RA = 8'h1C;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] bus_addr;
  logic       bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  rate_tick_irq u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual cycles=%0d expected <150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
      $finish;
    end
  end

  function automatic int period_exp(input int code);
    case (code)
      0: return 15; 1: return 13; 2: return 11; 3: return 10;
      4: return 9;  5: return 7;  6: return 3;  default: return 1;
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  // called at a negedge; write lands on the next posedge; returns at the following negedge
  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = RA; bus_wdata = 8'h00;
    #1;
  endtask

  task automatic rd_reg(output logic [7:0] v);
    bus_addr = RA; #1; v = bus_rdata;
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd_reg(v);
    chk("R1 reset register", v, 8'h00);
    chk("R1 reset irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_layout();
    logic [7:0] v;
    wr_reg(RA, 8'h74);
    rd_reg(v); chk("R2 rate/enable readback", v, 8'h74);
    wr_reg(RA, 8'hBD);
    rd_reg(v); chk("R3 bits 7,3,0 ignored/zero", v, 8'h34);
    wr_reg(RA, 8'h00);
    rd_reg(v); chk("R2 clear readback", v, 8'h00);
  endtask

  task automatic t_taps();
    logic [7:0] v;
    for (int code = 7; code >= 0; code--) begin
      logic [7:0] base;
      int p;
      base = 8'(code << 4);
      p = 1 << period_exp(code);
      wr_reg(RA, base);
      wr_reg(RA, base | 8'h08);
      rd_reg(v); chk("R5 rate code stopped", v, base);
      wr_reg(RA, base | 8'h02);
      wait_neg(p - 1);
      rd_reg(v); chk($sformatf("R5 R4 code %0d flag not yet", code), v[7:0] & 8'h80, 8'h00);
      wait_neg(1);
      rd_reg(v); chk($sformatf("R5 R4 code %0d flag at period", code), v & 8'h80, 8'h80);
      wr_reg(RA, base);
      wr_reg(RA, base | 8'h08);
    end
  endtask

  task automatic t_restart();
    logic [7:0] v;
    wr_reg(RA, 8'h52);
    wait_neg(50);
    wr_reg(RA, 8'h50);
    wait_neg(30);
    rd_reg(v); chk("R4 stopped no flag", v, 8'h50);
    wr_reg(RA, 8'h52);
    wait_neg(127);
    rd_reg(v); chk("R4 restart from zero", v & 8'h80, 8'h00);
    wait_neg(1);
    rd_reg(v); chk("R4 restart full period", v & 8'h80, 8'h80);
    wr_reg(RA, 8'h50);
    wr_reg(RA, 8'h58);
  endtask

  task automatic t_sticky();
    logic [7:0] v;
    wr_reg(RA, 8'h62);
    wait_neg(20);
    rd_reg(v); chk("R6 flag sticky over rollovers", v, 8'hE2);
    wr_reg(RA, 8'h62);
    rd_reg(v); chk("R7 ack 0 no effect", v, 8'hE2);
    wr_reg(RA, 8'h60);
    rd_reg(v); chk("R6 flag kept after stop", v, 8'hE0);
    wr_reg(RA, 8'h68);
    rd_reg(v); chk("R7 ack 1 clears", v, 8'h60);
  endtask

  task automatic t_collide();
    logic [7:0] v;
    wr_reg(RA, 8'h72);      // start, period 2
    wait_neg(1);
    wr_reg(RA, 8'h7A);      // lands on rollover edge
    rd_reg(v); chk("R8 rollover beats ack", v, 8'hF2);
    wr_reg(RA, 8'h7A);      // lands between rollovers
    rd_reg(v); chk("R7 ack clears off-edge", v, 8'h72);
    wait_neg(1);
    rd_reg(v); chk("R6 set again next rollover", v, 8'hF2);
    wr_reg(RA, 8'h70);
    wr_reg(RA, 8'h78);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    wr_reg(RA, 8'h72);
    wait_neg(3);
    chk("R9 irq low when disabled", {7'b0, irq}, 8'h00);
    wr_reg(RA, 8'h76);
    chk("R9 irq high flag+enable", {7'b0, irq}, 8'h01);
    wr_reg(RA, 8'h04);
    chk("R9 irq stays after stop", {7'b0, irq}, 8'h01);
    wr_reg(RA, 8'h0C);
    chk("R9 irq low after ack", {7'b0, irq}, 8'h00);
    rd_reg(v); chk("R9 register after ack", v, 8'h04);
    wr_reg(RA, 8'h00);
  endtask

  task automatic t_other();
    logic [7:0] v;
    wr_reg(8'h1D, 8'h76);
    wait_neg(4);
    rd_reg(v); chk("R10 foreign write ignored", v, 8'h00);
    bus_addr = 8'h1D; #1;
    chk("R10 foreign read zero", bus_rdata, 8'h00);
    bus_addr = RA; #1;
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = RA; bus_wr = 1'b0; bus_wdata = 8'h00;
    wait_neg(3);
    rst_n = 1'b1;
    wait_neg(4);
    t_reset();
    t_layout();
    t_other();
    t_irq();
    t_sticky();
    t_collide();
    t_restart();
    t_taps();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule